// File: doc/BRIEF.md
# Branch and Subroutine Sequencer

This block produces the next program counter of a 32-bit processor for every control-transfer instruction. It handles relative branches with 8-bit or 16-bit two's complement offsets, conditional branches tested against the N, Z and V flags, absolute jumps, and subroutine calls and returns. The offset is added to the instruction's own location plus two. A conditional branch whose test fails falls through to the instruction that follows, skipping any extension word.

Calls store their return address on a descending stack through a single-word memory port. Returns load the new program counter from the stack. The stack pointer is held inside the block and moves by one 4-byte slot per access. The decoder presents one command with `cmd_valid_i`. The block takes it only while `busy_o` is low, and it marks completion with a one-cycle `done_o` pulse. The result stays on `npc_o` and `taken_o` until the next completion.

Top module: `branch_seq_unit`

## Requirements
- R1: After reset `sp_o` equals the parameter `SP_RESET` (default 0x0000_0400), and `done_o`, `busy_o`, `mem_req_o`, `taken_o` and `npc_o` are all zero.
- R2: A relative target is `pc_i + 2` plus the offset sign-extended to 32 bits. The offset is `disp_i[7:0]` when `long_i` is 0 and `disp_i[15:0]` when `long_i` is 1. The sum wraps modulo 2^32.
- R3: `cond_i` selects the branch test, with `flags_i` = {N,Z,V,C} (bit 3 to bit 0). The tests are: 0 always; 1 Z; 2 !Z; 3 N==V; 4 !Z && N==V; 5 Z || N!=V; 6 N!=V; 7 never.
- R4: When a conditional branch (kind 0) fails its test, and for the unused kind codes 5 to 7, `npc_o` is `pc_i + 2` (short) or `pc_i + 4` (long) and `taken_o` is 0.
- R5: A relative call (kind 1) first lowers `sp_o` by 4. It then writes the following-instruction address (`pc_i + 2` short, `pc_i + 4` long) to the new `sp_o` value, and completes with the relative target of R2 and `taken_o` = 1.
- R6: An absolute call (kind 2) pushes `pc_i + 2 + 2*ext_words_i` in the same way as R5 and completes with `npc_o` = `tgt_i`.
- R7: A return (kind 3) reads the word at `sp_o`, completes with that word on `npc_o` and `taken_o` = 1, and raises `sp_o` by 4.
- R8: A jump (kind 4) and all branches complete with no memory request and no change to `sp_o`; a jump gives `npc_o` = `tgt_i`, `taken_o` = 1.
- R9: Commands without a stack access raise `done_o` in the cycle after acceptance. Stack commands hold `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` steady until `mem_ack_i`, and raise `done_o` in the cycle after the acknowledged one.
- R10: `cmd_valid_i` is ignored while `busy_o` is high: no second command is started, and `sp_o` and the result are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| kind_i | input | 3 | Command kind: 0 branch, 1 relative call, 2 absolute call, 3 return, 4 jump |
| cond_i | input | 3 | Branch test select |
| long_i | input | 1 | 16-bit offset with one extension word |
| disp_i | input | 16 | Branch offset |
| ext_words_i | input | 2 | Extension word count of an absolute call |
| pc_i | input | 32 | Location of the current instruction |
| tgt_i | input | 32 | Absolute target address |
| flags_i | input | 4 | Condition flags {N,Z,V,C} |
| busy_o | output | 1 | Stack access in progress |
| done_o | output | 1 | Completion pulse |
| npc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Control transfer taken |
| sp_o | output | 32 | Stack pointer |
| mem_req_o | output | 1 | Stack memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Stack word address |
| mem_wdata_o | output | 32 | Pushed word |
| mem_rdata_i | input | 32 | Popped word |
| mem_ack_i | input | 1 | Request accepted this cycle |

## Verification
The case that is hardest to reach from the ports is a new command arriving while a stack access waits for its acknowledge. The bench reaches it by holding `cmd_valid_i` high with a different jump command throughout a stretched push wait. It then checks that only the original result appears, that exactly one `done_o` pulse occurs, and that the stack pointer moved by a single slot. The random part varies the memory wait from zero to three cycles and keeps a bench-side stack, so that nested calls and returns are checked against independently computed addresses. Directed cases cover extreme offsets, address wrap and every flag test on both its true and its false side.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [2:0] {
    KIND_BCC = 3'd0,
    KIND_BSR = 3'd1,
    KIND_JSR = 3'd2,
    KIND_RTS = 3'd3,
    KIND_JMP = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    CC_T  = 3'd0,
    CC_EQ = 3'd1,
    CC_NE = 3'd2,
    CC_GE = 3'd3,
    CC_GT = 3'd4,
    CC_LE = 3'd5,
    CC_LT = 3'd6,
    CC_F  = 3'd7
  } cond_e;

  typedef enum logic [1:0] {
    STK_NONE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;
  localparam int FLAGS_W = 4;
endpackage

// File: rtl/bsu_cond_eval.sv
module bsu_cond_eval
  import bsu_pkg::*;
(
  input  logic [2:0]         cond_i,
  input  logic [FLAGS_W-1:0] flags_i,
  output logic               ok_o
);
  logic n_f, z_f, v_f, nv_match;

  assign n_f      = flags_i[FLAG_N];
  assign z_f      = flags_i[FLAG_Z];
  assign v_f      = flags_i[FLAG_V];
  assign nv_match = (n_f == v_f);

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_T:    ok_o = 1'b1;
      CC_EQ:   ok_o = z_f;
      CC_NE:   ok_o = !z_f;
      CC_GE:   ok_o = nv_match;
      CC_GT:   ok_o = !z_f && nv_match;
      CC_LE:   ok_o = z_f || !nv_match;
      CC_LT:   ok_o = !nv_match;
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsu_target_calc.sv
module bsu_target_calc #(
  parameter int ADDR_W  = 32,
  parameter int DISP_W  = 16,
  parameter int SHORT_W = 8,
  parameter int EXTC_W  = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              long_i,
  input  logic [EXTC_W-1:0] ext_words_i,
  output logic [ADDR_W-1:0] rel_o,
  output logic [ADDR_W-1:0] fall_o,
  output logic [ADDR_W-1:0] call_ret_o
);
  localparam int OPW_BYTES = DISP_W / 8;  // bytes per opcode/extension word

  logic [ADDR_W-1:0] base, off_short, off_long, off_sel, ext_bytes;

  assign off_short = {{(ADDR_W-SHORT_W){disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
  assign off_long  = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign off_sel   = long_i ? off_long : off_short;

  assign base       = pc_i + ADDR_W'(OPW_BYTES);
  assign rel_o      = base + off_sel;
  assign fall_o     = long_i ? base + ADDR_W'(OPW_BYTES) : base;
  assign ext_bytes  = ADDR_W'(ext_words_i) * ADDR_W'(OPW_BYTES);
  assign call_ret_o = base + ext_bytes;
endmodule

// File: rtl/bsu_seq_ctrl.sv
module bsu_seq_ctrl
  import bsu_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              SLOT_BYTES = 4,
  parameter logic [ADDR_W-1:0] SP_RESET = 32'h0000_0400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  stk_op_e           op_i,
  input  logic [ADDR_W-1:0] push_data_i,
  input  logic [ADDR_W-1:0] next_i,
  input  logic              taken_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] npc_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] mem_wdata_o,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_POP} state_e;

  localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(SLOT_BYTES);

  state_e            state_q;
  logic [ADDR_W-1:0] sp_q, wdata_q, pend_q, npc_q;
  logic              done_q, taken_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sp_q    <= SP_RESET;
      wdata_q <= '0;
      pend_q  <= '0;
      npc_q   <= '0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            unique case (op_i)
              STK_PUSH: begin
                sp_q    <= sp_q - SLOT;  // pre-decrement
                wdata_q <= push_data_i;
                pend_q  <= next_i;
                state_q <= ST_PUSH;
              end
              STK_POP: state_q <= ST_POP;
              default: begin
                npc_q   <= next_i;
                taken_q <= taken_i;
                done_q  <= 1'b1;
              end
            endcase
          end
        end
        ST_PUSH: begin
          if (mem_ack_i) begin
            npc_q   <= pend_q;
            taken_q <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_POP: begin
          if (mem_ack_i) begin
            npc_q   <= mem_rdata_i;
            sp_q    <= sp_q + SLOT;  // post-increment
            taken_q <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign npc_o       = npc_q;
  assign taken_o     = taken_q;
  assign sp_o        = sp_q;
  assign mem_req_o   = busy_o;
  assign mem_we_o    = (state_q == ST_PUSH);
  assign mem_addr_o  = sp_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/branch_seq_unit.sv
module branch_seq_unit
  import bsu_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DISP_W     = 16,
  parameter int                SHORT_W    = 8,
  parameter int                EXTC_W     = 2,
  parameter int                SLOT_BYTES = 4,
  parameter logic [ADDR_W-1:0] SP_RESET   = 32'h0000_0400
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [2:0]         kind_i,
  input  logic [2:0]         cond_i,
  input  logic               long_i,
  input  logic [DISP_W-1:0]  disp_i,
  input  logic [EXTC_W-1:0]  ext_words_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [ADDR_W-1:0]  tgt_i,
  input  logic [FLAGS_W-1:0] flags_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [ADDR_W-1:0]  npc_o,
  output logic               taken_o,
  output logic [ADDR_W-1:0]  sp_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [ADDR_W-1:0]  mem_wdata_o,
  input  logic [ADDR_W-1:0]  mem_rdata_i,
  input  logic               mem_ack_i
);
  logic              cond_ok, dec_taken;
  logic [ADDR_W-1:0] rel_tgt, fall_pc, call_ret, dec_next, dec_push;
  stk_op_e           dec_op;

  bsu_cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_i),
    .ok_o    (cond_ok)
  );

  bsu_target_calc #(
    .ADDR_W  (ADDR_W),
    .DISP_W  (DISP_W),
    .SHORT_W (SHORT_W),
    .EXTC_W  (EXTC_W)
  ) u_tgt (
    .pc_i        (pc_i),
    .disp_i      (disp_i),
    .long_i      (long_i),
    .ext_words_i (ext_words_i),
    .rel_o       (rel_tgt),
    .fall_o      (fall_pc),
    .call_ret_o  (call_ret)
  );

  always_comb begin
    dec_op    = STK_NONE;
    dec_next  = fall_pc;
    dec_push  = '0;
    dec_taken = 1'b0;
    unique case (kind_i)
      KIND_BCC: begin
        dec_taken = cond_ok;
        dec_next  = cond_ok ? rel_tgt : fall_pc;
      end
      KIND_BSR: begin
        dec_op    = STK_PUSH;
        dec_push  = fall_pc;
        dec_next  = rel_tgt;
        dec_taken = 1'b1;
      end
      KIND_JSR: begin
        dec_op    = STK_PUSH;
        dec_push  = call_ret;
        dec_next  = tgt_i;
        dec_taken = 1'b1;
      end
      KIND_RTS: begin
        dec_op    = STK_POP;
        dec_taken = 1'b1;
      end
      KIND_JMP: begin
        dec_next  = tgt_i;
        dec_taken = 1'b1;
      end
      default: ;
    endcase
  end

  bsu_seq_ctrl #(
    .ADDR_W     (ADDR_W),
    .SLOT_BYTES (SLOT_BYTES),
    .SP_RESET   (SP_RESET)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cmd_valid_i),
    .op_i        (dec_op),
    .push_data_i (dec_push),
    .next_i      (dec_next),
    .taken_i     (dec_taken),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .npc_o       (npc_o),
    .taken_o     (taken_o),
    .sp_o        (sp_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i)
  );
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
  parameter int ADDR_W     = 32,
  parameter int SLOT_BYTES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] npc_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] mem_wdata_o,
  input logic [ADDR_W-1:0] mem_rdata_i,
  input logic              mem_ack_i
);
  localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(SLOT_BYTES);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o));

  // R7
  pop_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i |=> done_o
      && npc_o == $past(mem_rdata_i) && sp_o == $past(sp_o) + SLOT);

  // R5
  push_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> done_o && sp_o == $past(sp_o));

  // R5
  sp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_o != $past(sp_o) |-> (sp_o == $past(sp_o) - SLOT) || (sp_o == $past(sp_o) + SLOT));

  // R8
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind branch_seq_unit bsu_checker #(
  .ADDR_W     (ADDR_W),
  .SLOT_BYTES (SLOT_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .npc_o       (npc_o),
  .sp_o        (sp_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/branch_seq_unit_tb_top.sv
module branch_seq_unit_tb_top;
  localparam logic [31:0] SP0 = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  kind = '0, cond = '0;
  logic        lng = 1'b0;
  logic [15:0] disp = '0;
  logic [1:0]  extw = '0;
  logic [31:0] pc = '0, tgt = '0;
  logic [3:0]  flags = '0;
  logic        busy, done, taken, mreq, mwe;
  logic [31:0] npc, sp, maddr, mwdata;
  logic [31:0] mrdata = '0;
  logic        mack = 1'b0;

  int n_vec = 0, n_bad = 0;
  logic [31:0] smem [256];
  logic [31:0] mstk [64];
  int          depth = 0;
  logic [31:0] exp_sp = SP0;

  always #10 clk = ~clk;

  branch_seq_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .kind_i(kind), .cond_i(cond),
    .long_i(lng), .disp_i(disp), .ext_words_i(extw), .pc_i(pc), .tgt_i(tgt),
    .flags_i(flags), .busy_o(busy), .done_o(done), .npc_o(npc), .taken_o(taken),
    .sp_o(sp), .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .mem_ack_i(mack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cc_ok(input logic [2:0] c, input logic [3:0] f);
    logic n, z, v;
    n = f[3]; z = f[2]; v = f[1];
    case (c)
      3'd0: return 1'b1;
      3'd1: return z;
      3'd2: return !z;
      3'd3: return n == v;
      3'd4: return !z && (n == v);
      3'd5: return z || (n != v);
      3'd6: return n != v;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] rel_tgt(input logic [31:0] p, input logic [15:0] d, input logic l);
    logic [31:0] off;
    off = l ? {{16{d[15]}}, d} : {{24{d[7]}}, d[7:0]};
    return p + 32'd2 + off;
  endfunction

  function automatic logic [31:0] next_seq(input logic [31:0] p, input logic l);
    return p + (l ? 32'd4 : 32'd2);
  endfunction

  // Issue one command; optionally hold a jump on cmd_valid_i while busy.
  task automatic run_cmd(input logic [2:0] k, input logic [2:0] c, input logic l,
                         input logic [15:0] d, input logic [1:0] e, input logic [31:0] p,
                         input logic [31:0] t, input logic [3:0] f, input int wait_n,
                         input bit intrude);
    logic [31:0] e_npc, e_wd;
    logic        e_tk;
    int          op;  // 0 none, 1 push, 2 pop
    int          cnt;
    bit          got;
    op = 0; e_wd = '0; e_tk = 1'b0; e_npc = next_seq(p, l);
    case (k)
      3'd0: begin e_tk = cc_ok(c, f); if (e_tk) e_npc = rel_tgt(p, d, l); end
      3'd1: begin op = 1; e_wd = next_seq(p, l); e_npc = rel_tgt(p, d, l); e_tk = 1'b1; end
      3'd2: begin op = 1; e_wd = p + 32'd2 + 32'(e) * 32'd2; e_npc = t; e_tk = 1'b1; end
      3'd3: begin op = 2; e_npc = mstk[depth-1]; e_tk = 1'b1; end
      3'd4: begin e_npc = t; e_tk = 1'b1; end
      default: ;
    endcase
    @(negedge clk);
    valid = 1'b1; kind = k; cond = c; lng = l; disp = d; extw = e; pc = p; tgt = t; flags = f;
    @(negedge clk);
    if (intrude) begin
      kind = 3'd4; tgt = 32'hDEAD_0000;
    end else valid = 1'b0;
    if (op == 0) begin
      chk("R9 done after 1 cycle", 32'(done), 32'd1);
      chk(k == 3'd0 && e_tk ? "R2/R3 branch target" : (k == 3'd4 ? "R8 jump target" : "R4 fall-through"), npc, e_npc);
      chk(k == 3'd0 ? "R3 taken" : "R4/R8 taken", 32'(taken), 32'(e_tk));
      chk("R8 no mem req", 32'(mreq), 32'd0);
      chk("R8 sp unchanged", sp, exp_sp);
    end else begin
      if (op == 1) exp_sp = exp_sp - 32'd4;
      chk(op == 1 ? "R5 push addr" : "R7 pop addr", maddr, exp_sp);
      chk(op == 1 ? "R5 write enable" : "R7 read enable", 32'(mwe), op == 1 ? 32'd1 : 32'd0);
      if (op == 1) chk(k == 3'd1 ? "R5 return address" : "R6 return address", mwdata, e_wd);
      cnt = 0; got = 0;
      while (!got) begin
        if (!mreq) begin
          chk("R9 req held", 32'(mreq), 32'd1);
          break;
        end
        chk("R9 addr stable", maddr, exp_sp);
        mrdata = smem[maddr[9:2]];
        if (cnt == wait_n) begin
          mack = 1'b1; got = 1;
          if (mwe) smem[maddr[9:2]] = mwdata;
        end else cnt++;
        @(negedge clk);
        mack = 1'b0;
        if (!got) chk("R9 no early done", 32'(done), 32'd0);
      end
      valid = 1'b0;
      if (op == 1) begin mstk[depth] = e_wd; depth++; end
      else begin depth--; exp_sp = exp_sp + 32'd4; end
      chk("R9 stack done", 32'(done), 32'd1);
      chk(k == 3'd3 ? "R7 popped pc" : (k == 3'd1 ? "R5 call target" : "R6 call target"), npc, e_npc);
      chk(k == 3'd3 ? "R7 taken" : "R5/R6 taken", 32'(taken), 32'd1);
      chk(k == 3'd3 ? "R7 sp raised" : "R5 sp lowered", sp, exp_sp);
      if (intrude) begin
        @(negedge clk);
        chk("R10 no second done", 32'(done), 32'd0);
        chk("R10 result kept", npc, e_npc);
        chk("R10 sp kept", sp, exp_sp);
        chk("R10 not busy", 32'(busy), 32'd0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) smem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sp", sp, SP0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 req", 32'(mreq), 32'd0);
    chk("R1 npc", npc, 32'd0);
    chk("R1 taken", 32'(taken), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 offset extremes and wrap
    run_cmd(3'd0, 3'd0, 1'b0, 16'h0080, 2'd0, 32'h0000_1000, 0, 4'h0, 0, 0);
    run_cmd(3'd0, 3'd0, 1'b0, 16'hFF7F, 2'd0, 32'h0000_1000, 0, 4'h0, 0, 0);
    run_cmd(3'd0, 3'd0, 1'b1, 16'h7FFF, 2'd0, 32'h0000_2000, 0, 4'h0, 0, 0);
    run_cmd(3'd0, 3'd0, 1'b1, 16'h8000, 2'd0, 32'h0000_2000, 0, 4'h0, 0, 0);
    run_cmd(3'd0, 3'd0, 1'b0, 16'h0010, 2'd0, 32'hFFFF_FFFC, 0, 4'h0, 0, 0);
    // R3 every test with passing and failing flags, R4 fall-through
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f += 2)
        run_cmd(3'd0, 3'(c), 1'(f[1]), 16'h0040, 2'd0, 32'h0000_3000, 0, 4'(f), 0, 0);
    // R4 unused kinds
    run_cmd(3'd5, 3'd0, 1'b1, 16'h0040, 2'd0, 32'h0000_4000, 32'h55, 4'h4, 0, 0);
    run_cmd(3'd7, 3'd0, 1'b0, 16'h0040, 2'd0, 32'h0000_4000, 32'h55, 4'h4, 0, 0);
    // R8 jump
    run_cmd(3'd4, 3'd0, 1'b0, 16'h0000, 2'd0, 32'h0000_4000, 32'h0001_2344, 4'h0, 0, 0);
    // R5 R6 R7 nested call/return, R10 intruder during a long wait
    run_cmd(3'd1, 3'd0, 1'b0, 16'h00F0, 2'd0, 32'h0000_5000, 0, 4'h0, 0, 0);
    run_cmd(3'd2, 3'd0, 1'b0, 16'h0000, 2'd2, 32'h0000_6000, 32'h0000_7000, 4'h0, 2, 1);
    run_cmd(3'd1, 3'd0, 1'b1, 16'hFFF0, 2'd0, 32'h0000_7000, 0, 4'h0, 3, 1);
    run_cmd(3'd3, 3'd0, 1'b0, 16'h0000, 2'd0, 32'h0000_8000, 0, 4'h0, 1, 1);
    run_cmd(3'd3, 3'd0, 1'b0, 16'h0000, 2'd0, 32'h0000_8000, 0, 4'h0, 0, 0);
    run_cmd(3'd3, 3'd0, 1'b0, 16'h0000, 2'd0, 32'h0000_8000, 0, 4'h0, 3, 0);

    // mixed random commands
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [2:0] k;
      r = $urandom_range(0, 9);
      if (r <= 4) k = 3'd0;
      else if (r == 5) k = (depth < 60) ? 3'd1 : 3'd0;
      else if (r == 6) k = (depth < 60) ? 3'd2 : 3'd4;
      else if (r == 7) k = (depth > 0) ? 3'd3 : 3'd4;
      else if (r == 8) k = 3'd4;
      else k = 3'($urandom_range(5, 7));
      run_cmd(k, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 16'($urandom),
              2'($urandom_range(0, 2)), $urandom & 32'hFFFF_FFFE, $urandom & 32'hFFFF_FFFE,
              4'($urandom_range(0, 15)), $urandom_range(0, 3), $urandom_range(0, 7) == 0);
    end

    while (depth > 0) run_cmd(3'd3, 3'd0, 1'b0, 16'h0, 2'd0, 32'h0, 32'h0, 4'h0, 0, 0);
    chk("R7 stack balanced", sp, SP0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule